// File: doc/BRIEF.md
# Two-Wire Register-Pointer Slave

This block is a target-side agent for a two-wire serial bus. It samples the bus clock (SCL) and data (SDA) lines with a faster system clock and recognises its own 7-bit bus address. Through a one-byte index register, it lets a bus host reach a bank of eight 8-bit registers. The bank sits outside the block on a simple parallel port: a one-cycle write strobe with index and data, and a combinational read path addressed by the current index.

A write transaction carries the index byte, optionally followed by one data byte for the indexed register. A read transaction returns exactly one byte from the register the index selects. The index keeps its value between transactions, so a host reads a register by first sending an index-only write and then a read. The block drives SDA only as an open-drain pull-down enable.

Top module: `i2c_ptr_slave`

## Requirements
- R1: The first frame after a start carries eight bits, MSB first: bits 7..1 are the 7-bit target address and bit 0 is the direction (0 = host writes, 1 = host reads). When bits 7..1 equal the `OWN_ADDR` parameter, the block pulls SDA low (sda_oe = 1) during the ninth SCL high of that frame.
- R2: When the address does not match, the block keeps sda_oe at 0 and issues no register write until the next start.
- R3: sda_oe changes only while SCL is low. SDA is sampled on SCL rising edges, and the drive is updated after SCL falling edges.
- R4: In a write, the first byte after the address is loaded into the index and acknowledged. If a stop follows it, no register is written.
- R5: A second write byte is acknowledged and produces exactly one wr_en pulse carrying the index and the byte.
- R6: Any third or later write byte in the same transaction is not acknowledged and causes no write.
- R7: A read returns the register selected by the index, MSB first. The index does not auto-increment, so two reads in a row return the same byte.
- R8: During the ninth clock of a read byte, and afterwards until the next start, the block leaves SDA released.
- R9: An index of 8 or more is acknowledged, but a data byte written to it produces no wr_en, and a read from it returns 0x00.
- R10: A start, including a repeated start with no stop before it, restarts address reception from any state.
- R11: A stop ends the transaction at any point and releases SDA. A byte cut short by a stop changes nothing.
- R12: After reset, sda_oe = 0, wr_en = 0 and the index is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| wr_en | output | 1 | One-cycle register write strobe |
| wr_idx | output | 3 | Register written by wr_en |
| wr_data | output | 8 | Byte written by wr_en |
| reg_sel | output | 3 | Low bits of the index, for the bank read port |
| rd_data | input | 8 | Bank contents at reg_sel |

## Verification
The assertions assume that every SCL low and high phase lasts several system clocks. They also assume that SDA changes from the host happen only while SCL is low, apart from deliberate start and stop conditions. Under these assumptions an edge seen through the synchronizer is followed by a stable phase in which the block's drive update lands. The bench's host tasks hold each SCL quarter for ten system clocks and move SDA only in the middle of a low phase. Start and stop are built from the standard SCL-high SDA transitions, and one stop is deliberately placed in the middle of a byte.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_WR,
        ST_RD,
        ST_SKIP
    } i2cs_st_e;

    typedef struct packed {
        logic scl;
        logic sda;
    } i2cs_line_t;

    typedef struct packed {
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
    } i2cs_evt_t;

    localparam int BYTE_W = 8;

    function automatic logic addr_hit(input logic [7:0] frame, input logic [6:0] own);
        return frame[7:1] == own;
    endfunction

endpackage

// File: rtl/i2cs_sync.sv
module i2cs_sync
    import i2cs_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  i2cs_line_t raw,
    output i2cs_line_t synced
);
    logic [1:0] pipe [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) pipe[g] <= 2'b11;
                else     pipe[g] <= {raw.scl, raw.sda};
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) pipe[g] <= 2'b11;
                else     pipe[g] <= pipe[g-1];
            end
        end
    end

    assign synced.scl = pipe[STAGES-1][1];
    assign synced.sda = pipe[STAGES-1][0];
endmodule

// File: rtl/i2cs_cond.sv
module i2cs_cond
    import i2cs_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  i2cs_line_t cur,
    output i2cs_evt_t  ev
);
    i2cs_line_t prev;

    always_ff @(posedge clk) begin
        if (rst) prev <= '{scl: 1'b1, sda: 1'b1};
        else     prev <= cur;
    end

    always_comb begin
        ev.scl_rise = cur.scl & ~prev.scl;
        ev.scl_fall = ~cur.scl & prev.scl;
        ev.start    = cur.scl & prev.scl & prev.sda & ~cur.sda;
        ev.stop     = cur.scl & prev.scl & ~prev.sda & cur.sda;
    end
endmodule

// File: rtl/i2cs_fsm.sv
module i2cs_fsm
    import i2cs_pkg::*;
#(
    parameter logic [6:0] OWN_ADDR = 7'h48,
    parameter int         NREG     = 8,
    localparam int        IW       = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst,
    input  i2cs_evt_t     ev,
    input  logic          sda,
    input  logic [7:0]    rd_data,
    output logic          sda_oe,
    output logic          wr_en,
    output logic [IW-1:0] wr_idx,
    output logic [7:0]    wr_data,
    output logic [IW-1:0] reg_sel,
    output i2cs_st_e      st
);
    localparam logic [7:0] NREG_B = 8'(NREG);

    logic [3:0] bitcnt;
    logic [7:0] shreg;
    logic [7:0] tx;
    logic [7:0] ptr;
    logic [1:0] nbyte;
    logic       rnw;
    logic [7:0] rd_eff;

    assign reg_sel = ptr[IW-1:0];
    assign rd_eff  = (ptr < NREG_B) ? rd_data : 8'h00;

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= ST_IDLE;
            bitcnt  <= '0;
            shreg   <= '0;
            tx      <= '0;
            ptr     <= '0;
            nbyte   <= '0;
            rnw     <= 1'b0;
            sda_oe  <= 1'b0;
            wr_en   <= 1'b0;
            wr_idx  <= '0;
            wr_data <= '0;
        end else begin
            wr_en <= 1'b0;
            if (ev.start) begin
                st     <= ST_ADDR;
                bitcnt <= '0;
                nbyte  <= '0;
                sda_oe <= 1'b0;
            end else if (ev.stop) begin
                st     <= ST_IDLE;
                sda_oe <= 1'b0;
            end else if (st == ST_ADDR || st == ST_WR || st == ST_RD) begin
                if (ev.scl_rise) begin
                    if (bitcnt != 4'd9) bitcnt <= bitcnt + 4'd1;
                    if (bitcnt < 4'd8)  shreg  <= {shreg[6:0], sda};
                    if (bitcnt == 4'd8 && st == ST_RD) st <= ST_SKIP;
                end else if (ev.scl_fall) begin
                    if (bitcnt == 4'd8) begin
                        case (st)
                            ST_ADDR: begin
                                if (addr_hit(shreg, OWN_ADDR)) begin
                                    sda_oe <= 1'b1;
                                    rnw    <= shreg[0];
                                end else begin
                                    st <= ST_SKIP;
                                end
                            end
                            ST_WR: begin
                                if (nbyte == 2'd0) begin
                                    ptr    <= shreg;
                                    sda_oe <= 1'b1;
                                end else if (nbyte == 2'd1) begin
                                    sda_oe  <= 1'b1;
                                    wr_en   <= (ptr < NREG_B);
                                    wr_idx  <= ptr[IW-1:0];
                                    wr_data <= shreg;
                                end else begin
                                    sda_oe <= 1'b0;
                                end
                                if (nbyte != 2'd2) nbyte <= nbyte + 2'd1;
                            end
                            default: sda_oe <= 1'b0;
                        endcase
                    end else if (bitcnt == 4'd9) begin
                        bitcnt <= '0;
                        sda_oe <= 1'b0;
                        if (st == ST_ADDR) begin
                            if (rnw) begin
                                st     <= ST_RD;
                                tx     <= rd_eff;
                                sda_oe <= ~rd_eff[7];
                            end else begin
                                st <= ST_WR;
                            end
                        end
                    end else if (st == ST_RD && bitcnt != 4'd0) begin
                        sda_oe <= ~tx[3'(4'd7 - bitcnt)];
                    end
                end
            end
        end
    end
endmodule

// File: rtl/i2c_ptr_slave.sv
module i2c_ptr_slave
    import i2cs_pkg::*;
#(
    parameter logic [6:0] OWN_ADDR = 7'h48,
    parameter int         NREG     = 8,
    parameter int         SYNC_N   = 2,
    localparam int        IW       = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          scl_i,
    input  logic          sda_i,
    output logic          sda_oe,
    output logic          wr_en,
    output logic [IW-1:0] wr_idx,
    output logic [7:0]    wr_data,
    output logic [IW-1:0] reg_sel,
    input  logic [7:0]    rd_data
);
    i2cs_line_t raw_l;
    i2cs_line_t sync_l;
    i2cs_evt_t  ev;
    i2cs_st_e   fsm_st;

    assign raw_l.scl = scl_i;
    assign raw_l.sda = sda_i;

    i2cs_sync #(.STAGES(SYNC_N)) u_sync (
        .clk(clk), .rst(rst), .raw(raw_l), .synced(sync_l)
    );

    i2cs_cond u_cond (
        .clk(clk), .rst(rst), .cur(sync_l), .ev(ev)
    );

    i2cs_fsm #(.OWN_ADDR(OWN_ADDR), .NREG(NREG)) u_fsm (
        .clk(clk), .rst(rst), .ev(ev), .sda(sync_l.sda), .rd_data(rd_data),
        .sda_oe(sda_oe), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .reg_sel(reg_sel), .st(fsm_st)
    );
endmodule

// File: rtl/i2cs_chk.sv
module i2cs_chk
    import i2cs_pkg::*;
(
    input logic     clk,
    input logic     rst,
    input logic     scl_s,
    input logic     start,
    input logic     stop,
    input logic     sda_oe,
    input logic     wr_en,
    input i2cs_st_e st
);
    // R3: a new pull-down starts only in an SCL low phase
    p_oe_rise_low_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_oe) |-> !scl_s);

    // R5: each data commit is a single-cycle strobe
    p_wr_pulse_r5: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> !wr_en);

    // R11: a stop releases the line on the next cycle
    p_stop_release_r11: assert property (@(posedge clk) disable iff (rst)
        stop |=> !sda_oe);

    // R10: a start always re-enters address reception
    p_start_addr_r10: assert property (@(posedge clk) disable iff (rst)
        start |=> (st == ST_ADDR));

    // R2 / R8: idle or ignoring means the line is left alone
    p_quiet_idle_r2: assert property (@(posedge clk) disable iff (rst)
        (st == ST_IDLE || st == ST_SKIP) |-> !sda_oe);

    // R2: no register write while ignoring the bus
    p_skip_nowrite_r2: assert property (@(posedge clk) disable iff (rst)
        (st == ST_SKIP) |-> !wr_en);
endmodule

bind i2c_ptr_slave i2cs_chk u_chk (
    .clk(clk), .rst(rst), .scl_s(sync_l.scl), .start(ev.start), .stop(ev.stop),
    .sda_oe(sda_oe), .wr_en(wr_en), .st(fsm_st)
);

// File: tb/tb_i2c_ptr_slave.sv
module tb_i2c_ptr_slave;
    localparam logic [6:0] OWN = 7'h48;
    localparam int Q = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic sda_oe, wr_en;
    logic [2:0] wr_idx, reg_sel;
    logic [7:0] wr_data, rd_data;
    logic sda_line;

    logic [7:0] bank [8];
    logic [7:0] mdl_bank [8];
    logic [7:0] mdl_ptr;
    logic [10:0] exp_wr [$];

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #4 clk = ~clk;

    assign sda_line = sda_m & ~sda_oe;
    assign rd_data  = bank[reg_sel];

    i2c_ptr_slave #(.OWN_ADDR(OWN)) dut (
        .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_line),
        .sda_oe(sda_oe), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .reg_sel(reg_sel), .rd_data(rd_data)
    );

    always @(posedge clk) if (wr_en) bank[wr_idx] <= wr_data;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // reference model compared every clock: write strobes and line discipline
    int hi_cnt = 0;
    logic prev_oe = 1'b0;
    always @(negedge clk) begin
        if (!rst && !done) begin
            if (wr_en) begin
                if (exp_wr.size() == 0) begin
                    check(0, "R5 unexpected write", {wr_idx, wr_data}, 0);
                end else begin
                    logic [10:0] e;
                    e = exp_wr.pop_front();
                    check({wr_idx, wr_data} == e, "R5 write content", {wr_idx, wr_data}, e);
                end
            end
            if (scl_m && hi_cnt >= 6)
                check(sda_oe == prev_oe, "R3 drive moved in SCL high", sda_oe, prev_oe);
            hi_cnt  = scl_m ? hi_cnt + 1 : 0;
            prev_oe = sda_oe;
        end
    end

    task automatic w(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; w(Q);
        scl_m = 1'b1; w(Q);
        sda_m = 1'b0; w(Q);
        scl_m = 1'b0; w(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; w(Q);
        scl_m = 1'b1; w(Q);
        sda_m = 1'b1; w(Q);
    endtask

    task automatic clk_bit(input logic b, output logic seen);
        sda_m = b; w(Q);
        scl_m = 1'b1; w(Q / 2);
        seen = sda_line; w(Q / 2);
        scl_m = 1'b0; w(Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        logic s;
        for (int i = 7; i >= 0; i--) clk_bit(b[i], s);
        clk_bit(1'b1, s);
        ack = ~s;
    endtask

    task automatic recv_byte(output logic [7:0] b);
        logic s;
        for (int i = 7; i >= 0; i--) begin
            clk_bit(1'b1, s);
            b[i] = s;
        end
        sda_m = 1'b1; w(Q);
        scl_m = 1'b1; w(Q / 2);
        check(sda_oe == 1'b0, "R8 released on ninth clock", sda_oe, 0);
        w(Q / 2);
        scl_m = 1'b0; w(Q);
    endtask

    task automatic do_read(input string req, input logic [7:0] exp);
        logic a;
        logic [7:0] b;
        bus_start();
        send_byte({OWN, 1'b1}, a);
        check(a, "R1 read address ack", a, 1);
        recv_byte(b);
        check(b == exp, req, b, exp);
        bus_stop();
        check(sda_oe == 1'b0, "R11 released after stop", sda_oe, 0);
    endtask

    task automatic set_ptr(input logic [7:0] p);
        logic a;
        bus_start();
        send_byte({OWN, 1'b0}, a);
        check(a, "R1 write address ack", a, 1);
        send_byte(p, a);
        check(a, "R4 index byte ack", a, 1);
        bus_stop();
        mdl_ptr = p;
    endtask

    task automatic write_reg(input logic [7:0] p, input logic [7:0] d);
        logic a;
        bus_start();
        send_byte({OWN, 1'b0}, a);
        check(a, "R1 write address ack", a, 1);
        send_byte(p, a);
        check(a, "R4 index byte ack", a, 1);
        if (p < 8) begin
            exp_wr.push_back({p[2:0], d});
            mdl_bank[p[2:0]] = d;
        end
        send_byte(d, a);
        check(a, "R5 data byte ack", a, 1);
        mdl_ptr = p;
    endtask

    function automatic logic [7:0] mdl_read();
        return (mdl_ptr < 8) ? mdl_bank[mdl_ptr[2:0]] : 8'h00;
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            fails++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", checks, fails);
            $finish;
        end
    end

    initial begin
        logic a;
        logic [7:0] b;
        for (int i = 0; i < 8; i++) begin
            bank[i]     = 8'h10 + 8'(i);
            mdl_bank[i] = 8'h10 + 8'(i);
        end
        mdl_ptr = 8'h00;
        w(5);
        rst = 1'b0;
        w(3);
        check(sda_oe == 0 && wr_en == 0 && reg_sel == 0, "R12 reset state",
              {sda_oe, wr_en, reg_sel}, 0);
        do_read("R12 index 0 after reset", mdl_read());

        // R5: index then data
        write_reg(8'd3, 8'hA5);
        bus_stop();
        // R4/R7: index-only write, then two reads of the same register
        set_ptr(8'd3);
        do_read("R7 read selected register", mdl_read());
        do_read("R7 no auto-increment", mdl_read());

        // R6: third byte refused
        write_reg(8'd5, 8'h3C);
        send_byte(8'h77, a);
        check(!a, "R6 third byte not acked", a, 0);
        bus_stop();
        set_ptr(8'd5);
        do_read("R6 third byte not stored", mdl_read());

        // R2: foreign address, write direction
        bus_start();
        send_byte({OWN ^ 7'h01, 1'b0}, a);
        check(!a, "R2 foreign address not acked", a, 0);
        send_byte(8'h02, a);
        check(!a, "R2 foreign index not acked", a, 0);
        send_byte(8'h11, a);
        check(!a, "R2 foreign data not acked", a, 0);
        bus_stop();
        do_read("R2 index unchanged by foreign write", mdl_read());

        // R9: index out of the bank
        write_reg(8'd9, 8'h55);
        bus_stop();
        do_read("R9 out-of-range read is zero", 8'h00);

        // R10: repeated start from a write into a read
        bus_start();
        send_byte({OWN, 1'b0}, a);
        send_byte(8'd3, a);
        check(a, "R10 index ack before repeated start", a, 1);
        mdl_ptr = 8'd3;
        bus_start();
        send_byte({OWN, 1'b1}, a);
        check(a, "R10 address ack after repeated start", a, 1);
        recv_byte(b);
        check(b == mdl_read(), "R10 read after repeated start", b, mdl_read());
        bus_stop();

        // R2: foreign address, read direction
        bus_start();
        send_byte({OWN ^ 7'h10, 1'b1}, a);
        check(!a, "R2 foreign read not acked", a, 0);
        recv_byte(b);
        check(b == 8'hFF, "R2 foreign read line released", b, 8'hFF);
        bus_stop();

        // R11: stop in the middle of an index byte
        bus_start();
        send_byte({OWN, 1'b0}, a);
        for (int i = 0; i < 4; i++) begin
            logic s;
            clk_bit(1'(i & 1), s);
        end
        bus_stop();
        check(sda_oe == 1'b0, "R11 released after mid-byte stop", sda_oe, 0);
        do_read("R11 cut byte left index alone", mdl_read());

        w(20);
        check(exp_wr.size() == 0, "R5 all expected writes seen", exp_wr.size(), 0);
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end
endmodule